// File: doc/BRIEF.md
# GPIO port with per-pin interrupt detection

This block is a 32-pin general-purpose I/O port that software controls through a small synchronous register bus. Software sets the direction of each pin and the value it drives. It can also read the pad levels after they have been synchronized to the block clock. The block drives an output vector and an output-enable vector toward the pad ring and takes a pad input vector back. It does not model the tristate buffers or any pin multiplexing.

Each pin watches its synchronized input for one of four conditions, selected by a two-bit code. When the condition holds, a sticky status bit for that pin is set. Software clears a status bit by writing a one to it. A per-pin enable mask decides which status bits reach the single combined interrupt line. A read is requested with the read strobe and its data appears on the read data bus one cycle later.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is zero: all pins are inputs (`pad_oe` = 0), `pad_out` = 0, all interrupts are masked and `irq` is low.
- R2: `pad_out` equals the output data register (offset 0x00), and `pad_oe` equals the direction register (offset 0x04), where a 1 makes a pin an output; both follow a write on the cycle after it.
- R3: A read with `bus_re` high returns on `bus_rdata` one cycle later the last value written to 0x00, 0x04, 0x0C, 0x10 or 0x14.
- R4: Reading offset 0x08 returns the pad inputs after a two-flop synchronizer.
- R5: A read of any offset other than 0x00 to 0x18 returns zero.
- R6: Each pin has a 2-bit condition code: 0 low level, 1 high level, 2 rising edge, 3 falling edge. Pins 0 to 15 take their code from 0x0C and pins 16 to 31 from 0x10, with pin n at bits [2*(n mod 16)+1 : 2*(n mod 16)]. An edge is found by comparing the synchronized value with its value one cycle earlier.
- R7: A status bit is set when its condition is met, whether or not its mask bit is set.
- R8: `irq` is the OR over all pins of (status AND mask), where the mask is at 0x14 and a mask bit of 1 enables the pin.
- R9: Writing to the status register at 0x18 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: While a level condition persists, its status bit is set again every cycle, so a set wins over a write-one clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the strobe |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined port interrupt |

## Verification
The detector is exercised with a rising step on two pins that carry different codes, so only the pin with the rising code may latch. A later falling step separates the falling code from the rising one. A held high level on one pin, cleared while the level stays, shows that the set wins over the clear. A low level on an upper-half pin shows that the second configuration register and the low-level code are decoded at the right bit position. The mask is toggled around pending bits to show that it gates only the interrupt line and never the status.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_re,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int HALF = NPIN / 2;
  localparam logic [AW-1:0] OFF_DATA = AW'('h00);
  localparam logic [AW-1:0] OFF_DIR  = AW'('h04);
  localparam logic [AW-1:0] OFF_PAD  = AW'('h08);
  localparam logic [AW-1:0] OFF_CLO  = AW'('h0C);
  localparam logic [AW-1:0] OFF_CHI  = AW'('h10);
  localparam logic [AW-1:0] OFF_MASK = AW'('h14);
  localparam logic [AW-1:0] OFF_STAT = AW'('h18);

  logic [NPIN-1:0] data_q, dir_q, mask_q, status_q;
  logic [NPIN-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] hit, clr;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] code;
    if (i < HALF) begin : g_lo
      assign code = cfg_lo_q[2*i +: 2];
    end else begin : g_hi
      assign code = cfg_hi_q[2*(i-HALF) +: 2];
    end
    assign hit[i] = (code == 2'd0) ? ~sync2_q[i] :
                    (code == 2'd1) ?  sync2_q[i] :
                    (code == 2'd2) ? (sync2_q[i] & ~prev_q[i]) :
                                     (~sync2_q[i] & prev_q[i]);
  end

  assign clr     = (bus_we && bus_addr == OFF_STAT) ? bus_wdata : '0;
  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq     = |(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      sync1_q  <= pad_in;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
      status_q <= (status_q & ~clr) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFF_DATA: data_q   <= bus_wdata;
        OFF_DIR:  dir_q    <= bus_wdata;
        OFF_CLO:  cfg_lo_q <= bus_wdata;
        OFF_CHI:  cfg_hi_q <= bus_wdata;
        OFF_MASK: mask_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        OFF_DATA: bus_rdata <= data_q;
        OFF_DIR:  bus_rdata <= dir_q;
        OFF_PAD:  bus_rdata <= sync2_q;
        OFF_CLO:  bus_rdata <= cfg_lo_q;
        OFF_CHI:  bus_rdata <= cfg_hi_q;
        OFF_MASK: bus_rdata <= mask_q;
        OFF_STAT: bus_rdata <= status_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] bus_wdata,
  input logic            bus_re,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] pad_out,
  input logic            irq,
  input logic [NPIN-1:0] status_q
);
  a_r1_no_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  a_r2_data_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == AW'('h00)) |-> pad_out == $past(bus_wdata));

  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && bus_addr == AW'('h1C)) |-> bus_rdata == '0);

  a_r8_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == AW'('h14) && bus_wdata == '0) |-> !irq);

  a_r9_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(bus_we && bus_addr == AW'('h18))) |-> (($past(status_q) & ~status_q) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .irq(irq), .status_q(status_q)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) pend <= bus_re;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(5'h04, 32'h0, "R1 dir");
    rd(5'h14, 32'h0, "R1 mask");
    rd(5'h0C, 32'h0, "R1 cfg_lo");

    wr(5'h00, 32'hA5A5_1234);
    wr(5'h04, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'hA5A5_1234);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h00, 32'hA5A5_1234, "R3 data");
    rd(5'h04, 32'hFFFF_0000, "R3 dir");

    pad_in = 32'h1357_9BDF;
    idle(3);
    rd(5'h08, 32'h1357_9BDF, "R4 pad status");
    rd(5'h1C, 32'h0, "R5 unmapped");
    pad_in = 32'h0;
    idle(4);

    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, 32'h0, "R9 clear all");
    rd(5'h0C, 32'hAAAA_AAAA, "R3 cfg_lo");
    rd(5'h10, 32'hFFFF_FFFF, "R3 cfg_hi");

    pad_in = 32'h0001_0001;
    idle(4);
    rd(5'h18, 32'h0000_0001, "R6 rise pin0 only");
    check("R7 masked status no irq", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h0000_0001);
    check("R8 irq on unmask", {31'h0, irq}, 32'h1);
    rd(5'h14, 32'h0000_0001, "R3 mask");

    pad_in = 32'h0;
    idle(4);
    rd(5'h18, 32'h0001_0001, "R6 fall pin16");
    wr(5'h18, 32'h0000_0001);
    rd(5'h18, 32'h0001_0000, "R9 partial clear");
    check("R8 irq after clear", {31'h0, irq}, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, 32'h0, "R9 clear rest");

    wr(5'h0C, 32'hAAAA_AAA6);
    pad_in = 32'h0000_0002;
    idle(4);
    rd(5'h18, 32'h0000_0002, "R6 high level pin1");
    wr(5'h18, 32'h0000_0002);
    rd(5'h18, 32'h0000_0002, "R10 level beats clear");
    wr(5'h14, 32'h0000_0002);
    check("R8 irq level", {31'h0, irq}, 32'h1);
    pad_in = 32'h0;
    idle(4);
    wr(5'h18, 32'h0000_0002);
    rd(5'h18, 32'h0, "R10 clear after level ends");
    check("R8 irq drops", {31'h0, irq}, 32'h0);

    wr(5'h10, 32'hFFFF_FFF3);
    idle(2);
    rd(5'h18, 32'h0002_0000, "R6 low level pin17");
    check("R7 low level masked", {31'h0, irq}, 32'h0);

    idle(3);
    check("scoreboard drained", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule